// File: doc/BRIEF.md
# Split-Read 64-bit Cycle Counter with Tear Detection

This block keeps a 64-bit cycle counter that software can only see through a 32-bit auxiliary register port. It reads the counter as two halves: first the lower word, then the upper word. Because the counter keeps running between those two accesses, the block watches the access sequence itself. A status bit then reports whether the last low/high pair can be joined into one coherent 64-bit value.

A pair counts as torn in two cases. The first is when the interrupt-taken input pulses after the low read and up to and including the high read. The second is when the upper word has changed since the low read. Software reads low, then high, then the control/status register. It repeats those three reads until the coherence bit is set. The counter is started and stopped through bit 0 of the control/status register.

Top module: `cyc64_snapshot_timer`

## Requirements
- R1: After reset the counter holds `CNT_INIT` (default zero), the enable is off, the coherence bit is 0 and the read data output is zero.
- R2: A write to address 0x103 loads the enable from write-data bit 0, effective from the next edge. A read of 0x103 returns the enable in bit 0, the coherence flag in bit 31, and zero in bits 30 to 1.
- R3: While enabled, the counter increases by exactly one on every clock edge, starting one edge after the enabling write. While disabled, it holds its value.
- R4: A read strobe to 0x104 returns the lower 32 bits of the counter as sampled at the strobe edge. Read data appears after that edge and is held until the next read strobe.
- R5: A read strobe to 0x105 returns the upper 32 bits of the counter as sampled at the strobe edge.
- R6: After a low read followed by a high read with no tearing event between them, bit 31 of 0x103 reads 1.
- R7: An interrupt-taken pulse after the low read, up to and including the cycle of the high read, makes bit 31 read 0. A pulse in the same cycle as the low read does not tear the pair.
- R8: If the upper word sampled at the high read differs from its value at the low read, bit 31 reads 0.
- R9: Bit 31 reads 0 after any other sequence: a high read with no pending low read, a low read not yet followed by a high read, or a second high read. A low read clears the flag. Reading 0x103 does not change the flag.
- R10: Writes to 0x104 and 0x105 have no effect on the counter or the read values.
- R11: The lower word wraps from 0xFFFFFFFF to 0 with a carry into the upper word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| aux_addr | input | 12 | Auxiliary register address |
| aux_wdata | input | 32 | Write data |
| aux_wr | input | 1 | Write strobe |
| aux_rd | input | 1 | Read strobe |
| irq_taken | input | 1 | Pulse: an interrupt or exception was taken |
| aux_rdata | output | 32 | Registered read data |

## Verification
Each read strobe is sampled on one clock edge. Its data, and any change to the coherence flag, is visible from that edge on. The bench records the index of that edge and samples at the following falling edge.

Counter values are predicted from edge indices. A read at edge t returns `CNT_INIT + t - 1 - Ew`, where Ew is the edge of the enabling write. A disabling write at edge Ed freezes the counter at `CNT_INIT + Ed - Ew`.

The carry case uses a second instance whose initial value sits just under the 32-bit boundary. The bench waits for the edge at which the low read returns 0xFFFFFFFF. The high read then lands two edges later, after the carry.

// File: rtl/snap_tmr_pkg.sv
package snap_tmr_pkg;

    localparam int AUX_AW = 12;
    localparam int WORD_W = 32;

    localparam logic [AUX_AW-1:0] ADR_CTRL = 12'h103;
    localparam logic [AUX_AW-1:0] ADR_LO   = 12'h104;
    localparam logic [AUX_AW-1:0] ADR_HI   = 12'h105;

    localparam int EN_BIT = 0;

    typedef enum logic {
        TRK_IDLE,
        TRK_LO_SEEN
    } trk_state_e;

    typedef struct packed {
        logic rd_ctrl;
        logic rd_lo;
        logic rd_hi;
        logic wr_ctrl;
    } aux_hit_s;

    function automatic aux_hit_s decode_hit(input logic [AUX_AW-1:0] a,
                                            input logic rd,
                                            input logic wr);
        aux_hit_s h;
        h.rd_ctrl = rd && (a == ADR_CTRL);
        h.rd_lo   = rd && (a == ADR_LO);
        h.rd_hi   = rd && (a == ADR_HI);
        h.wr_ctrl = wr && (a == ADR_CTRL);
        return h;
    endfunction

endpackage

// File: rtl/snap_tmr_counter.sv
module snap_tmr_counter
    import snap_tmr_pkg::*;
#(
    parameter int            CW   = 2 * WORD_W,
    parameter logic [CW-1:0] INIT = '0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    output logic [CW-1:0] cnt
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= INIT;
        end else if (en) begin
            cnt <= cnt + CW'(1);
        end
    end

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        en |=> (cnt == $past(cnt) + CW'(1)));   // R3

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(cnt));                  // R3

endmodule

// File: rtl/snap_tmr_tracker.sv
module snap_tmr_tracker
    import snap_tmr_pkg::*;
#(
    parameter int WW = WORD_W
) (
    input  logic          clk,
    input  logic          rst,
    input  aux_hit_s      hit,
    input  logic          irq,
    input  logic [WW-1:0] cnt_hi,
    output logic          ok
);

    trk_state_e    state;
    logic          torn;
    logic [WW-1:0] hi_snap;
    logic          pair_good;

    // A pair is good only if a low read is pending and no tear has been
    // seen. An irq in the high-read cycle also tears, and so does an
    // upper word that moved since the low read.
    always_comb begin
        pair_good = (state == TRK_LO_SEEN) && !torn && !irq
                    && (cnt_hi == hi_snap);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= TRK_IDLE;
            torn    <= 1'b0;
            hi_snap <= '0;
            ok      <= 1'b0;
        end else if (hit.rd_lo) begin
            state   <= TRK_LO_SEEN;
            torn    <= 1'b0;
            hi_snap <= cnt_hi;
            ok      <= 1'b0;
        end else if (hit.rd_hi) begin
            state   <= TRK_IDLE;
            torn    <= 1'b0;
            ok      <= pair_good;
        end else if (irq && state == TRK_LO_SEEN) begin
            torn    <= 1'b1;
        end
    end

    AST_OK_FROM_HI: assert property (@(posedge clk) disable iff (rst)
        $rose(ok) |-> $past(hit.rd_hi));                            // R6

    AST_IRQ_TEARS: assert property (@(posedge clk) disable iff (rst)
        (hit.rd_hi && irq) |=> !ok);                                // R7

    AST_HI_MOVED: assert property (@(posedge clk) disable iff (rst)
        (hit.rd_hi && state == TRK_LO_SEEN && cnt_hi != hi_snap) |=> !ok); // R8

    AST_LO_RESTARTS: assert property (@(posedge clk) disable iff (rst)
        hit.rd_lo |=> !ok);                                         // R9

    AST_HI_NO_PENDING: assert property (@(posedge clk) disable iff (rst)
        (hit.rd_hi && state == TRK_IDLE) |=> !ok);                  // R9

endmodule

// File: rtl/snap_tmr_regif.sv
module snap_tmr_regif
    import snap_tmr_pkg::*;
#(
    parameter  int WW = WORD_W,
    localparam int CW = 2 * WW
) (
    input  logic          clk,
    input  logic          rst,
    input  aux_hit_s      hit,
    input  logic [WW-1:0] wdata,
    input  logic [CW-1:0] cnt,
    input  logic          ok,
    output logic          en,
    output logic [WW-1:0] rdata
);

    logic [WW-1:0] status_word;
    logic [WW-1:0] rd_mux;
    logic          any_rd;

    always_comb begin
        status_word         = '0;
        status_word[WW-1]   = ok;
        status_word[EN_BIT] = en;
    end

    always_comb begin
        any_rd = hit.rd_lo || hit.rd_hi || hit.rd_ctrl;
        rd_mux = '0;
        if (hit.rd_lo) begin
            rd_mux = cnt[WW-1:0];
        end else if (hit.rd_hi) begin
            rd_mux = cnt[CW-1:WW];
        end else if (hit.rd_ctrl) begin
            rd_mux = status_word;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en    <= 1'b0;
            rdata <= '0;
        end else begin
            if (hit.wr_ctrl) begin
                en <= wdata[EN_BIT];
            end
            if (any_rd) begin
                rdata <= rd_mux;
            end
        end
    end

    AST_EN_LOAD: assert property (@(posedge clk) disable iff (rst)
        hit.wr_ctrl |=> (en == $past(wdata[EN_BIT])));  // R2

    AST_EN_KEEP: assert property (@(posedge clk) disable iff (rst)
        !hit.wr_ctrl |=> $stable(en));                  // R10

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !any_rd |=> $stable(rdata));                    // R4

endmodule

// File: rtl/cyc64_snapshot_timer.sv
module cyc64_snapshot_timer
    import snap_tmr_pkg::*;
#(
    parameter  int            WW       = WORD_W,
    localparam int            CW       = 2 * WW,
    parameter  logic [CW-1:0] CNT_INIT = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [AUX_AW-1:0] aux_addr,
    input  logic [WW-1:0]     aux_wdata,
    input  logic              aux_wr,
    input  logic              aux_rd,
    input  logic              irq_taken,
    output logic [WW-1:0]     aux_rdata
);

    aux_hit_s      hit;
    logic          en;
    logic          ok;
    logic [CW-1:0] cnt;

    always_comb begin
        hit = decode_hit(aux_addr, aux_rd, aux_wr);
    end

    snap_tmr_counter #(
        .CW   (CW),
        .INIT (CNT_INIT)
    ) u_counter (
        .clk (clk),
        .rst (rst),
        .en  (en),
        .cnt (cnt)
    );

    snap_tmr_tracker #(
        .WW (WW)
    ) u_tracker (
        .clk    (clk),
        .rst    (rst),
        .hit    (hit),
        .irq    (irq_taken),
        .cnt_hi (cnt[CW-1:WW]),
        .ok     (ok)
    );

    snap_tmr_regif #(
        .WW (WW)
    ) u_regif (
        .clk   (clk),
        .rst   (rst),
        .hit   (hit),
        .wdata (aux_wdata),
        .cnt   (cnt),
        .ok    (ok),
        .en    (en),
        .rdata (aux_rdata)
    );

    AST_ONE_READ_TARGET: assert property (@(posedge clk) disable iff (rst)
        $countones({hit.rd_ctrl, hit.rd_lo, hit.rd_hi}) <= 1);  // R4

endmodule

// File: tb/test_cyc64_snapshot_timer.sv
module test_cyc64_snapshot_timer;

    localparam int          CLK_PERIOD = 10;
    localparam logic [11:0] A_CTRL     = 12'h103;
    localparam logic [11:0] A_LO       = 12'h104;
    localparam logic [11:0] A_HI       = 12'h105;
    localparam logic [63:0] INIT_B     = 64'h0000_0000_FFFF_F000;

    // vector: {first sel, second sel, irq between, expected bit31}
    // sel: 0 = control, 1 = low, 2 = high
    localparam int          NVEC = 8;
    localparam logic [5:0]  VEC [NVEC] = '{
        {2'd1, 2'd2, 1'b0, 1'b1},
        {2'd1, 2'd2, 1'b1, 1'b0},
        {2'd2, 2'd2, 1'b0, 1'b0},
        {2'd1, 2'd1, 1'b0, 1'b0},
        {2'd1, 2'd0, 1'b0, 1'b0},
        {2'd2, 2'd1, 1'b0, 1'b0},
        {2'd1, 2'd2, 1'b0, 1'b1},
        {2'd0, 2'd2, 1'b0, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] aux_addr = '0;
    logic [31:0] aux_wdata = '0;
    logic        aux_wr = 1'b0;
    logic        aux_rd = 1'b0;
    logic        irq_taken = 1'b0;
    logic [31:0] rdata_a;
    logic [31:0] rdata_b;

    longint      cyc = 0;
    int          n_run = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    cyc64_snapshot_timer i_cyc64_snapshot_timer (
        .clk       (clk),
        .rst       (rst),
        .aux_addr  (aux_addr),
        .aux_wdata (aux_wdata),
        .aux_wr    (aux_wr),
        .aux_rd    (aux_rd),
        .irq_taken (irq_taken),
        .aux_rdata (rdata_a)
    );

    cyc64_snapshot_timer #(.CNT_INIT(INIT_B)) i_wrap (
        .clk       (clk),
        .rst       (rst),
        .aux_addr  (aux_addr),
        .aux_wdata (aux_wdata),
        .aux_wr    (aux_wr),
        .aux_rd    (aux_rd),
        .irq_taken (irq_taken),
        .aux_rdata (rdata_b)
    );

    function automatic logic [11:0] sel_addr(input logic [1:0] s);
        return (s == 2'd1) ? A_LO : (s == 2'd2) ? A_HI : A_CTRL;
    endfunction

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic do_rd(input logic [11:0] a, input logic with_irq,
                         output logic [31:0] da, output logic [31:0] db,
                         output longint e);
        @(negedge clk);
        aux_addr  = a;
        aux_rd    = 1'b1;
        irq_taken = with_irq;
        @(posedge clk);
        #1 e = cyc;
        @(negedge clk);
        aux_rd    = 1'b0;
        irq_taken = 1'b0;
        da = rdata_a;
        db = rdata_b;
    endtask

    task automatic do_wr(input logic [11:0] a, input logic [31:0] d,
                         output longint e);
        @(negedge clk);
        aux_addr  = a;
        aux_wdata = d;
        aux_wr    = 1'b1;
        @(posedge clk);
        #1 e = cyc;
        @(negedge clk);
        aux_wr = 1'b0;
    endtask

    task automatic pulse_irq();
        @(negedge clk);
        irq_taken = 1'b1;
        @(negedge clk);
        irq_taken = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] da, db, hold;
        longint      e, ew, ed, elo, ehi;
        logic [63:0] vb;

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        check("R1", "rdata after reset", {32'h0, rdata_a}, 64'h0);
        do_rd(A_CTRL, 1'b0, da, db, e);
        check("R1", "ctrl after reset", {32'h0, da}, 64'h0);
        do_rd(A_HI, 1'b0, da, db, e);
        check("R1", "hi after reset", {32'h0, da}, 64'h0);
        do_rd(A_LO, 1'b0, da, db, e);
        check("R1", "lo after reset", {32'h0, da}, 64'h0);
        check("R1", "init value inst b", {32'h0, db}, {32'h0, INIT_B[31:0]});
        repeat (5) @(negedge clk);
        do_rd(A_LO, 1'b0, da, db, e);
        check("R3", "disabled counter holds", {32'h0, da}, 64'h0);

        // R2: enable and readback
        do_wr(A_CTRL, 32'hFFFF_FFFF, ew);
        do_rd(A_CTRL, 1'b0, da, db, e);
        check("R2", "ctrl readback", {32'h0, da}, 64'h1);

        // R3/R4/R5: counting and readout
        do_rd(A_LO, 1'b0, da, db, e);
        check("R4", "lo value", {32'h0, da}, 64'(e - 1 - ew));
        hold = da;
        repeat (4) @(negedge clk);
        check("R4", "rdata held", {32'h0, rdata_a}, {32'h0, hold});
        do_rd(A_LO, 1'b0, da, db, e);
        check("R3", "lo advances", {32'h0, da}, 64'(e - 1 - ew));
        do_rd(A_HI, 1'b0, da, db, e);
        check("R5", "hi value", {32'h0, da}, 64'h0);

        // R10: writes to data registers ignored
        do_wr(A_LO, 32'hDEAD_BEEF, e);
        do_wr(A_HI, 32'h1234_5678, e);
        do_rd(A_LO, 1'b0, da, db, e);
        check("R10", "lo after data writes", {32'h0, da}, 64'(e - 1 - ew));
        do_rd(A_HI, 1'b0, da, db, e);
        check("R10", "hi after data writes", {32'h0, da}, 64'h0);
        do_rd(A_CTRL, 1'b0, da, db, e);
        check("R10", "enable kept", {63'h0, da[0]}, 64'h1);

        // R6/R7/R9: sequence table
        for (int i = 0; i < NVEC; i++) begin
            do_rd(sel_addr(VEC[i][5:4]), 1'b0, da, db, e);
            if (VEC[i][1]) pulse_irq();
            do_rd(sel_addr(VEC[i][3:2]), 1'b0, da, db, e);
            do_rd(A_CTRL, 1'b0, da, db, e);
            check(VEC[i][0] ? "R6" : (VEC[i][1] ? "R7" : "R9"),
                  $sformatf("vector %0d bit31", i), {63'h0, da[31]},
                  {63'h0, VEC[i][0]});
            check("R2", $sformatf("vector %0d reserved bits", i),
                  {32'h0, 1'b0, da[30:0]}, 64'h1);
        end

        // R7: irq on the low-read cycle does not tear
        do_rd(A_LO, 1'b1, da, db, e);
        do_rd(A_HI, 1'b0, da, db, e);
        do_rd(A_CTRL, 1'b0, da, db, e);
        check("R7", "irq with lo read", {63'h0, da[31]}, 64'h1);
        // R9: status read leaves flag alone
        do_rd(A_CTRL, 1'b0, da, db, e);
        check("R9", "second status read", {63'h0, da[31]}, 64'h1);
        // R7: irq on the high-read cycle tears
        do_rd(A_LO, 1'b0, da, db, e);
        do_rd(A_HI, 1'b1, da, db, e);
        do_rd(A_CTRL, 1'b0, da, db, e);
        check("R7", "irq with hi read", {63'h0, da[31]}, 64'h0);

        // R8/R11: carry between low and high reads (instance b)
        while (cyc < ew + 4096 - 1) begin
            @(posedge clk);
            #1;
        end
        do_rd(A_LO, 1'b0, da, db, elo);
        vb = INIT_B + 64'(elo - 1 - ew);
        check("R11", "lo before wrap", {32'h0, db}, {32'h0, vb[31:0]});
        check("R11", "lo is all ones", {32'h0, db}, 64'hFFFF_FFFF);
        do_rd(A_HI, 1'b0, da, db, ehi);
        vb = INIT_B + 64'(ehi - 1 - ew);
        check("R11", "hi after carry", {32'h0, db}, {32'h0, vb[63:32]});
        do_rd(A_CTRL, 1'b0, da, db, e);
        check("R8", "torn by hi change", {63'h0, db[31]}, 64'h0);
        do_rd(A_LO, 1'b0, da, db, elo);
        vb = INIT_B + 64'(elo - 1 - ew);
        check("R11", "lo after wrap", {32'h0, db}, {32'h0, vb[31:0]});
        do_rd(A_HI, 1'b0, da, db, ehi);
        check("R11", "hi stays one", {32'h0, db}, 64'h1);
        do_rd(A_CTRL, 1'b0, da, db, e);
        check("R6", "clean pair after wrap", {63'h0, db[31]}, 64'h1);

        // R3: disable freezes the counter
        do_wr(A_CTRL, 32'h0, ed);
        do_rd(A_CTRL, 1'b0, da, db, e);
        check("R2", "enable cleared", {63'h0, da[0]}, 64'h0);
        do_rd(A_LO, 1'b0, da, db, e);
        check("R3", "frozen value", {32'h0, da}, 64'(ed - ew));
        repeat (6) @(negedge clk);
        do_rd(A_LO, 1'b0, da, db, e);
        check("R3", "still frozen", {32'h0, da}, 64'(ed - ew));

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule